// File: doc/BRIEF.md
# Character LCD Command Decoder

This block models the panel side of a character LCD controller on a write-only parallel bus. It watches the register-select, enable and data lines from the system clock domain. It rebuilds each transferred byte from one enable pulse in 8-bit mode, or from two pulses in 4-bit mode, and then acts on the byte. A byte written with RS low is an instruction. A byte written with RS high is character data. The block keeps the mode state of the panel, an address counter, a display offset and an 80-entry display RAM. The RAM can be read through a side port.

Each accepted byte sets a busy flag for a fixed number of microsecond ticks. A controller driving the bus is expected to wait until busy clears before it sends the next byte. A byte that completes while busy is set is dropped and sets a sticky overrun flag. This lets a test bench or a model catch controllers that do not respect command timing.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset: busy, overrun, cg_sel, disp_on, cursor_on, blink_on, two_line, tall_font, addr_cnt and disp_ofs are 0; bus_8bit and inc_mode are 1.
- R2: Bus lines pass through a two-stage synchronizer. A byte or nibble is taken on the detected falling edge of lcd_e, and the byte acts on the state two clocks after that edge. In 8-bit mode a single pulse is a whole byte, so the power-up pulse 0x30 (only the upper lines set) is taken as a function-set byte.
- R3: A function-set byte with bit 4 = 0 selects 4-bit mode. In 4-bit mode each byte is two pulses on lcd_d[7:4], the upper nibble first. A function set with bit 4 = 1 returns the block to single-pulse bytes.
- R4: In 4-bit mode, if RS differs between the two nibbles of a pair, the pair is discarded with no effect on state or busy.
- R5: An instruction is chosen by its highest set bit: bit7 sets the DDRAM address, bit6 sets the CGRAM address, bit5 is function set, bit4 is cursor/display shift (busy only), bit3 is display control, bit2 is entry mode, bit1 is return home and bit0 is clear. The byte 0x00 does nothing.
- R6: Clear and return home hold busy for LONG_US ticks of us_tick. Every other instruction and every data write holds busy for SHORT_US ticks.
- R7: Entry mode sets inc_mode from bit1 and shift_mode from bit0. A data write in DDRAM mode stores the byte at addr_cnt and then steps addr_cnt up (inc_mode = 1) or down, wrapping within 0..79. When shift_mode is set, disp_ofs also steps the same way.
- R8: Display control loads disp_on, cursor_on and blink_on from bits 2, 1 and 0. Function set loads bus_8bit, two_line and the font bit from bits 4, 3 and 2. tall_font is the font bit gated off when two_line is 1.
- R9: Set DDRAM address loads bits 6:0, reduced by 80 when the value is 80 or more, and clears cg_sel. Set CGRAM address loads bits 5:0 and sets cg_sel. In CGRAM mode, data writes leave the display RAM untouched and step the counter modulo 64.
- R10: Clear fills every display RAM entry with 0x20, sets addr_cnt and disp_ofs to 0 and inc_mode to 1. Return home sets addr_cnt and disp_ofs to 0 and clears cg_sel.
- R11: A byte that completes while busy is 1 changes nothing and sets overrun, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lcd_rs | input | 1 | Register select: 0 = instruction, 1 = data |
| lcd_e | input | 1 | Enable strobe, data taken on its falling edge |
| lcd_d | input | 8 | Bus data; only [7:4] used in 4-bit mode |
| rd_addr | input | 7 | Display RAM read address |
| rd_data | output | 8 | Display RAM content at rd_addr (0 when out of range) |
| busy | output | 1 | Instruction or write in progress |
| overrun | output | 1 | Sticky: a byte arrived while busy |
| addr_cnt | output | 7 | Current address counter |
| cg_sel | output | 1 | Address counter targets CGRAM |
| inc_mode | output | 1 | Entry direction, 1 = increment |
| shift_mode | output | 1 | Display shifts on data writes |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Block cursor selected |
| bus_8bit | output | 1 | 8-bit bus mode |
| two_line | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall font in effect |
| disp_ofs | output | 7 | Display shift offset |

## Verification
A bad nibble-pairing state shows up at once: the next byte decodes as the wrong instruction, which moves addr_cnt or the mode outputs to values that differ from the expected ones two clocks after the final enable edge. A bad busy counter shows as busy clearing early or late against the tick count, or as a wrongly raised overrun. Errors in the address counter or the clear sweep stay hidden until the display RAM is read back. For this reason, RAM contents are compared at wrap points and after clear.

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder #(
  parameter int LONG_US  = 1520,
  parameter int SHORT_US = 37,
  parameter int DEPTH    = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       lcd_rs,
  input  logic       lcd_e,
  input  logic [7:0] lcd_d,
  input  logic [6:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       overrun,
  output logic [6:0] addr_cnt,
  output logic       cg_sel,
  output logic       inc_mode,
  output logic       shift_mode,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       tall_font,
  output logic [6:0] disp_ofs
);
  localparam int TW = $clog2(LONG_US + 1);
  localparam logic [6:0] LAST = 7'(DEPTH - 1);

  logic       e1, e2, rs1, rs2;
  logic [7:0] d1, d2;
  logic       half, hi_rs;
  logic [3:0] hi_nib;
  logic       font_bit;
  logic [TW-1:0] tmr;
  logic       clr_act;
  logic [6:0] clr_ptr;
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {e1, e2, rs1, rs2, d1, d2} <= '0;
    else        {e1, e2, rs1, rs2, d1, d2} <= {lcd_e, e1, lcd_rs, rs1, lcd_d, d1};

  wire fall = e2 & ~e1;

  logic       byte_ok, byte_rs;
  logic [7:0] byte_v;
  always_comb begin
    byte_ok = 1'b0;
    byte_rs = rs2;
    byte_v  = d2;
    if (fall) begin
      if (bus_8bit) byte_ok = 1'b1;
      else if (half) begin
        byte_ok = (rs2 == hi_rs);
        byte_v  = {hi_nib, d2[7:4]};
      end
    end
  end

  assign busy = (tmr != '0);
  wire exec = byte_ok & ~busy;

  logic [2:0] top;
  logic       hit;
  always_comb begin
    top = '0;
    hit = 1'b0;
    for (int i = 0; i < 8; i++)
      if (byte_v[i]) begin
        top = 3'(i);
        hit = 1'b1;
      end
  end

  logic [6:0] addr_nx, ofs_nx, dd_load;
  always_comb begin
    if (cg_sel)
      addr_nx = {1'b0, inc_mode ? addr_cnt[5:0] + 6'd1 : addr_cnt[5:0] - 6'd1};
    else if (inc_mode)
      addr_nx = (addr_cnt >= LAST) ? 7'd0 : addr_cnt + 7'd1;
    else
      addr_nx = (addr_cnt == 7'd0) ? LAST : addr_cnt - 7'd1;
    if (inc_mode) ofs_nx = (disp_ofs >= LAST) ? 7'd0 : disp_ofs + 7'd1;
    else          ofs_nx = (disp_ofs == 7'd0) ? LAST : disp_ofs - 7'd1;
    dd_load = (byte_v[6:0] >= 7'(DEPTH)) ? byte_v[6:0] - 7'(DEPTH) : byte_v[6:0];
  end

  assign tall_font = font_bit & ~two_line;
  assign rd_data   = (rd_addr < 7'(DEPTH)) ? ram[rd_addr] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0; hi_rs <= 1'b0; hi_nib <= '0;
      tmr <= '0; overrun <= 1'b0; clr_act <= 1'b0; clr_ptr <= '0;
      addr_cnt <= '0; disp_ofs <= '0; cg_sel <= 1'b0;
      inc_mode <= 1'b1; shift_mode <= 1'b0;
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      bus_8bit <= 1'b1; two_line <= 1'b0; font_bit <= 1'b0;
    end else begin
      if (fall && !bus_8bit) begin
        half <= ~half;
        if (!half) begin
          hi_nib <= d2[7:4];
          hi_rs  <= rs2;
        end
      end
      if (us_tick && busy) tmr <= tmr - 1'b1;
      if (clr_act) begin
        clr_ptr <= clr_ptr + 7'd1;
        if (clr_ptr == LAST) clr_act <= 1'b0;
      end
      if (byte_ok && busy) overrun <= 1'b1;
      if (exec && byte_rs) begin
        tmr <= TW'(SHORT_US);
        addr_cnt <= addr_nx;
        if (shift_mode && !cg_sel) disp_ofs <= ofs_nx;
      end else if (exec && hit) begin
        tmr <= (top <= 3'd1) ? TW'(LONG_US) : TW'(SHORT_US);
        case (top)
          3'd7: begin addr_cnt <= dd_load; cg_sel <= 1'b0; end
          3'd6: begin addr_cnt <= {1'b0, byte_v[5:0]}; cg_sel <= 1'b1; end
          3'd5: begin
            bus_8bit <= byte_v[4]; two_line <= byte_v[3]; font_bit <= byte_v[2];
          end
          3'd4: ;
          3'd3: begin disp_on <= byte_v[2]; cursor_on <= byte_v[1]; blink_on <= byte_v[0]; end
          3'd2: begin inc_mode <= byte_v[1]; shift_mode <= byte_v[0]; end
          3'd1: begin addr_cnt <= '0; disp_ofs <= '0; cg_sel <= 1'b0; end
          default: begin
            addr_cnt <= '0; disp_ofs <= '0; cg_sel <= 1'b0; inc_mode <= 1'b1;
            clr_act <= 1'b1; clr_ptr <= '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (clr_act) ram[clr_ptr] <= 8'h20;
    else if (exec && byte_rs && !cg_sel) ram[addr_cnt] <= byte_v;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R11
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && busy) |=> ($stable(addr_cnt) && overrun)); // R11
  AST_DDRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_sel |-> (addr_cnt < 7'(DEPTH))); // R9
  AST_NO_HALF_8BIT: assert property (@(posedge clk) disable iff (!rst_n) bus_8bit |-> !half); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick) |=> busy); // R6
  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n) clr_act |-> busy); // R10
endmodule

// File: tb/tb_lcd_cmd_decoder.sv
`timescale 1ns/1ps
module tb_lcd_cmd_decoder;
  logic clk = 0, rst_n = 0, us_tick = 1, lcd_rs = 0, lcd_e = 0;
  logic [7:0] lcd_d = '0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, overrun, cg_sel, inc_mode, shift_mode, disp_on, cursor_on, blink_on;
  logic bus_8bit, two_line, tall_font;
  logic [6:0] addr_cnt, disp_ofs;
  int checks = 0, fails = 0;
  bit four = 0;

  always #4 clk = ~clk;

  lcd_cmd_decoder dut (.*);

  localparam logic [15:0] VEC [12] = '{
    {1'b0, 8'h38, 7'd0}, {1'b0, 8'h0E, 7'd0}, {1'b0, 8'h06, 7'd0},
    {1'b1, 8'h41, 7'd1}, {1'b1, 8'h42, 7'd2}, {1'b0, 8'hCF, 7'd79},
    {1'b1, 8'h43, 7'd0}, {1'b0, 8'h04, 7'd0}, {1'b1, 8'h44, 7'd79},
    {1'b0, 8'hD5, 7'd5}, {1'b0, 8'h02, 7'd0}, {1'b0, 8'h45, 7'd5}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit rs, logic [7:0] d);
    @(negedge clk); lcd_rs = rs; lcd_d = d;
    repeat (2) @(negedge clk); lcd_e = 1;
    repeat (3) @(negedge clk); lcd_e = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(bit rs, logic [7:0] b);
    if (four) begin
      pulse(rs, {b[7:4], 4'h0});
      pulse(rs, {b[3:0], 4'h0});
    end else pulse(rs, b);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    if (busy) check("R6 busy stuck", 1, 0);
    @(negedge clk);
  endtask

  task automatic ram_at(int a, int exp, string req);
    @(negedge clk); rd_addr = 7'(a); #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0); check("R1 overrun", overrun, 0);
    check("R1 addr", addr_cnt, 0); check("R1 bus_8bit", bus_8bit, 1);
    check("R1 inc_mode", inc_mode, 1); check("R1 disp_on", disp_on, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      send(VEC[i][15], VEC[i][14:7]);
      wait_idle();
      check($sformatf("R5/R7/R9 vector %0d addr", i), addr_cnt, VEC[i][6:0]);
    end
    check("R9 cg_sel", cg_sel, 1);
    check("R8 disp_on", disp_on, 1); check("R8 cursor_on", cursor_on, 1);
    check("R8 two_line", two_line, 1); check("R8 blink_on", blink_on, 0);
    ram_at(0, 8'h44, "R7 ram[0]"); ram_at(1, 8'h42, "R7 ram[1]");
    ram_at(79, 8'h43, "R7 ram[79] wrap");
    send(1, 8'h99); wait_idle();
    check("R9 cg counter", addr_cnt, 4);
    ram_at(0, 8'h44, "R9 cg write leaves ram");
    send(0, 8'h00); wait_idle();
    check("R5 zero no-op addr", addr_cnt, 4);
    send(0, 8'h80); wait_idle();
    check("R9 ddram clears cg_sel", cg_sel, 0);

    send(0, 8'h0C);
    check("R6 busy set", busy, 1);
    repeat (30) @(negedge clk);
    check("R6 short busy held", busy, 1);
    repeat (10) @(negedge clk);
    check("R6 short busy ends", busy, 0);

    send(0, 8'h0C); send(0, 8'h83); wait_idle();
    check("R11 ignored addr", addr_cnt, 0);
    check("R11 overrun", overrun, 1);

    send(0, 8'h02);
    repeat (1000) @(negedge clk);
    check("R6 long busy", busy, 1);
    wait_idle();

    send(0, 8'h07); wait_idle();
    send(1, 8'h30); wait_idle();
    check("R7 shift ofs", disp_ofs, 1);
    send(0, 8'h04); wait_idle();
    send(0, 8'h01); wait_idle();
    check("R10 clear addr", addr_cnt, 0);
    check("R10 clear inc", inc_mode, 1);
    check("R10 clear ofs", disp_ofs, 0);
    ram_at(0, 8'h20, "R10 ram[0]"); ram_at(79, 8'h20, "R10 ram[79]");
    check("R11 overrun sticky", overrun, 1);

    send(0, 8'h28); wait_idle();
    check("R3 4-bit mode", bus_8bit, 0);
    four = 1;
    send(0, 8'h83); wait_idle();
    check("R3 nibble addr", addr_cnt, 3);
    pulse(1, 8'h40); pulse(0, 8'h10);
    check("R4 mismatch busy", busy, 0);
    check("R4 mismatch addr", addr_cnt, 3);
    send(1, 8'h41); wait_idle();
    check("R3 nibble data addr", addr_cnt, 4);
    ram_at(3, 8'h41, "R3 nibble data ram");
    send(0, 8'h24); wait_idle();
    check("R8 tall font", tall_font, 1);
    send(0, 8'h2C); wait_idle();
    check("R8 font ignored 2-line", tall_font, 0);
    send(0, 8'h30); wait_idle();
    check("R3 back to 8-bit", bus_8bit, 1);
    four = 0;
    send(0, 8'h85); wait_idle();
    check("R3 single pulse again", addr_cnt, 5);

    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    pulse(0, 8'h30);
    check("R2 power-up pulse busy", busy, 1);
    check("R2 stays 8-bit", bus_8bit, 1);
    check("R1 overrun cleared", overrun, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule